// File: doc/BRIEF.md
# Serial Frame Synchronizer with Flywheel

This block watches a serial bit stream, qualified by a per-bit strobe, and finds a programmable synchronization word that opens every frame. The correlator compares the most recent bits with the word on every strobe. Positions set in a mask are ignored. A match is declared while the number of differing unmasked bits stays within an error threshold. A four-state machine builds up and keeps trust in the frame timing. SEARCH hunts at every bit position. CHECK confirms candidate boundaries one frame apart. LOCK checks once per frame through a window that is widened to absorb bit slips. FLYWHEEL rides through a bounded run of missed sync words.

While the timing is trusted (LOCK or FLYWHEEL), the block re-emits the stream delayed so that each frame starts with its own sync word. It raises a frame-start pulse on the first bit of every accepted frame and holds a frame-valid level. When the enable input is low the block drops all framing and copies the raw stream to the output. The named transitions are:
- search-hit (SEARCH to CHECK, or to LOCK when the check count is zero)
- check-pass (stay in CHECK, or go to LOCK)
- check-fail (CHECK to SEARCH)
- lock-hit (stay in LOCK)
- lock-miss (LOCK to FLYWHEEL, or to SEARCH when the tolerance is zero)
- fly-hit (FLYWHEEL to LOCK)
- fly-miss (stay in FLYWHEEL, or to SEARCH)
- disable (any state to SEARCH)

Top module: `fsync_top`

## Requirements
- R1: With `enable` low, every strobed input bit appears on `data_out` with `data_vld` one clock later, `frame_start` and `frame_valid` stay low, and the state returns to SEARCH (0) on the next clock.
- R2: In SEARCH, the sync word is compared with the last SYNC_W received bits at every strobe, the newest bit being the word's bit 0 and the oldest its MSB. A match is declared when the mismatch count is at most `err_thr` (0 to 15). A search-hit leaves SEARCH; three errors with `err_thr`=2 do not.
- R3: A 1 in `sync_mask` bit k removes sync-word bit k from the comparison, so errors confined to masked positions never prevent a match.
- R4: In CHECK, the word is tested only when exactly `frame_len` bits have passed since the previous accepted sync end, and payload bits between the two boundaries are ignored. A check-fail at that boundary returns the state to SEARCH.
- R5: LOCK is reached on the (`ctl_thr`+1)-th consecutive correct sync word. With `ctl_thr`=0, the search-hit goes straight to LOCK and the frame holding that first sync word is output. No data is output in SEARCH or CHECK.
- R6: In LOCK and FLYWHEEL, a sync end is accepted anywhere from `frame_len`-N to `frame_len`+N bits after the previous boundary (N = `slip_win`, values above 2 act as 2), and the earliest hit wins. The bit counter re-aligns to the accepted position. If no hit arrives by the window's end, the frame counts as a miss.
- R7: A lock-miss enters FLYWHEEL (3). The block returns to SEARCH on the miss that makes the run of consecutive misses exceed `lts_thr`, so `lts_thr`=0 sends the first miss straight to SEARCH. Output and `frame_valid` continue in FLYWHEEL.
- R8: A fly-hit returns the block to LOCK and clears the miss run, so a later lock-miss again starts counting from one.
- R9: Outputs are registered one clock after the strobe. In-frame `data_out` lags the input by SYNC_W-1 bits, so the first output bit of an accepted frame is the sync word's MSB. That bit carries `frame_start`, the next SYNC_W-1 output bits are the rest of the sync word, and a missed frame carries no `frame_start`.
- R10: `state_out` encodes SEARCH=0, CHECK=1, LOCK=2, FLYWHEEL=3. `locked` is high in LOCK and FLYWHEEL. After reset the state is SEARCH with all outputs low, and the state does not change on cycles without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | 1: synchronize; 0: raw pass-through |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Strobe qualifying `bit_in` |
| frame_len | input | LEN_W (16) | Frame length in bits, sync word included |
| sync_word | input | SYNC_W (32) | Expected sync word, MSB sent first |
| sync_mask | input | SYNC_W (32) | 1 = ignore that sync-word bit |
| err_thr | input | CNT_W (4) | Tolerated mismatching bits |
| ctl_thr | input | CNT_W (4) | Extra confirmations before LOCK |
| lts_thr | input | CNT_W (4) | Tolerated consecutive misses |
| slip_win | input | 2 | Window widening N in bits (0..2) |
| data_out | output | 1 | Output bit |
| data_vld | output | 1 | `data_out` valid |
| frame_start | output | 1 | First bit of an accepted frame |
| frame_valid | output | 1 | Frame timing trusted |
| state_out | output | 2 | Current state code |
| locked | output | 1 | State is LOCK or FLYWHEEL |

## Verification
On every cycle, the assertions check that the block leaves SEARCH only on a correlator hit. They also check that an exact or fully masked comparison is always a hit, that LOCK and FLYWHEEL never fall back to CHECK, and that FLYWHEEL is entered only from trusted states. Further cycle checks cover framing flags and data only in trusted states, the pass-through copy when disabled, and a state that holds between strobes. Only the directed scenarios can show the counting behaviour across whole frames: the i+1 confirmation rule, payload immunity at non-boundary positions, the j-miss tolerance with its reset on a fly-hit, re-alignment after early and late slips, and the exact bit order of the delayed output.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_CHECK  = 2'd1,
        ST_LOCK   = 2'd2,
        ST_FLY    = 2'd3
    } fs_state_t;

    localparam int MAX_SLIP = 2;
endpackage

// File: rtl/fsync_corr.sv
module fsync_corr #(
    parameter int SYNC_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [SYNC_W-1:0] sync_mask,
    input  logic [CNT_W-1:0]  err_thr,
    output logic              hit,
    output logic              lead_bit
);
    localparam int ERR_W = $clog2(SYNC_W + 1) + 1;

    logic [SYNC_W-1:0] hist;
    logic [SYNC_W-1:0] view;
    logic [SYNC_W-1:0] diff;
    logic [ERR_W-1:0]  errs;

    // window including the bit presented this cycle
    assign view     = {hist[SYNC_W-2:0], bit_in};
    assign diff     = (view ^ sync_word) & ~sync_mask;
    assign lead_bit = view[SYNC_W-1];

    always_comb begin
        errs = '0;
        for (int k = 0; k < SYNC_W; k++) begin
            errs = errs + ERR_W'(diff[k]);
        end
    end

    assign hit = (errs <= ERR_W'(err_thr));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (bit_vld) begin
            hist <= view;
        end
    end

    // R2: an exact window always matches
    p_exact_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (view == sync_word) |-> hit);

    // R3: a fully masked word can never be rejected
    p_full_mask_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&sync_mask) |-> hit);
endmodule

// File: rtl/fsync_ctrl.sv
module fsync_ctrl
    import fsync_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bit_vld,
    input  logic             hit,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [CNT_W-1:0] ctl_thr,
    input  logic [CNT_W-1:0] lts_thr,
    input  logic [1:0]       slip_win,
    output fs_state_t        state,
    output logic             emit,
    output logic             sof,
    output logic             framing
);
    localparam int POS_W = LEN_W + 2;

    fs_state_t        st_n;
    logic [POS_W-1:0] pos, pos_n, cur, nom, lo, hi, slip;
    logic [CNT_W-1:0] chk, chk_n, miss, miss_n;
    logic             in_win, win_end, chk_done, give_up;

    assign slip     = (slip_win > 2'(MAX_SLIP)) ? POS_W'(MAX_SLIP) : POS_W'(slip_win);
    assign nom      = POS_W'(frame_len);
    assign lo       = nom - slip;
    assign hi       = nom + slip;
    assign cur      = pos + 1'b1;
    assign in_win   = (cur >= lo);
    assign win_end  = (cur >= hi);
    assign chk_done = ({1'b0, chk} + 1'b1) == {1'b0, ctl_thr};
    assign give_up  = ({1'b0, miss} + 1'b1) > {1'b0, lts_thr};

    // next-state and event logic
    always_comb begin
        st_n   = state;
        pos_n  = pos;
        chk_n  = chk;
        miss_n = miss;
        emit   = 1'b0;
        sof    = 1'b0;
        if (!enable) begin
            st_n   = ST_SEARCH;
            pos_n  = '0;
            chk_n  = '0;
            miss_n = '0;
        end else if (bit_vld) begin
            unique case (state)
                ST_SEARCH: begin
                    if (hit) begin
                        pos_n  = '0;
                        chk_n  = '0;
                        miss_n = '0;
                        if (ctl_thr == '0) begin
                            st_n = ST_LOCK;
                            emit = 1'b1;
                            sof  = 1'b1;
                        end else begin
                            st_n = ST_CHECK;
                        end
                    end
                end
                ST_CHECK: begin
                    pos_n = cur;
                    if (cur >= nom) begin
                        pos_n = '0;
                        if (!hit) begin
                            st_n  = ST_SEARCH;
                            chk_n = '0;
                        end else if (chk_done) begin
                            st_n  = ST_LOCK;
                            chk_n = '0;
                            emit  = 1'b1;
                            sof   = 1'b1;
                        end else begin
                            chk_n = chk + 1'b1;
                        end
                    end
                end
                ST_LOCK, ST_FLY: begin
                    emit  = 1'b1;
                    pos_n = cur;
                    if (in_win && hit) begin
                        st_n   = ST_LOCK;
                        pos_n  = '0;
                        miss_n = '0;
                        sof    = 1'b1;
                    end else if (win_end) begin
                        if (give_up) begin
                            st_n   = ST_SEARCH;
                            pos_n  = '0;
                            miss_n = '0;
                            emit   = 1'b0;
                        end else begin
                            st_n   = ST_FLY;
                            pos_n  = slip;
                            miss_n = miss + 1'b1;
                        end
                    end
                end
                default: st_n = ST_SEARCH;
            endcase
        end
    end

    assign framing = (st_n == ST_LOCK) || (st_n == ST_FLY);

    // state and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SEARCH;
            pos   <= '0;
            chk   <= '0;
            miss  <= '0;
        end else begin
            state <= st_n;
            pos   <= pos_n;
            chk   <= chk_n;
            miss  <= miss_n;
        end
    end

    p_disable_to_search_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_SEARCH));

    p_search_needs_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH && !(enable && bit_vld && hit)) |=> (state == ST_SEARCH));

    p_no_check_after_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK || state == ST_FLY) |=> (state != ST_CHECK));

    p_fly_from_trusted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEARCH || state == ST_CHECK) |=> (state != ST_FLY));

    p_fly_has_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLY) |-> (miss != '0));

    p_hold_between_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !bit_vld) |=> $stable(state));
endmodule

// File: rtl/fsync_top.sv
module fsync_top
    import fsync_pkg::*;
#(
    parameter int SYNC_W = 32,
    parameter int LEN_W  = 16,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic [SYNC_W-1:0] sync_word,
    input  logic [SYNC_W-1:0] sync_mask,
    input  logic [CNT_W-1:0]  err_thr,
    input  logic [CNT_W-1:0]  ctl_thr,
    input  logic [CNT_W-1:0]  lts_thr,
    input  logic [1:0]        slip_win,
    output logic              data_out,
    output logic              data_vld,
    output logic              frame_start,
    output logic              frame_valid,
    output logic [1:0]        state_out,
    output logic              locked
);
    fs_state_t state;
    logic      hit, lead_bit, emit, sof, framing;

    fsync_corr #(.SYNC_W(SYNC_W), .CNT_W(CNT_W)) u_corr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_vld   (bit_vld),
        .sync_word (sync_word),
        .sync_mask (sync_mask),
        .err_thr   (err_thr),
        .hit       (hit),
        .lead_bit  (lead_bit)
    );

    fsync_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .bit_vld   (bit_vld),
        .hit       (hit),
        .frame_len (frame_len),
        .ctl_thr   (ctl_thr),
        .lts_thr   (lts_thr),
        .slip_win  (slip_win),
        .state     (state),
        .emit      (emit),
        .sof       (sof),
        .framing   (framing)
    );

    assign state_out = state;
    assign locked    = (state == ST_LOCK) || (state == ST_FLY);

    // output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out    <= 1'b0;
            data_vld    <= 1'b0;
            frame_start <= 1'b0;
            frame_valid <= 1'b0;
        end else if (!enable) begin
            data_out    <= bit_in;
            data_vld    <= bit_vld;
            frame_start <= 1'b0;
            frame_valid <= 1'b0;
        end else begin
            data_vld    <= bit_vld && emit;
            frame_start <= bit_vld && sof;
            frame_valid <= framing;
            if (bit_vld && emit) begin
                data_out <= lead_bit;
            end
        end
    end

    p_bypass_no_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!frame_start && !frame_valid));

    p_bypass_copy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && bit_vld) |=> (data_vld && data_out == $past(bit_in)));

    p_no_data_untrusted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && !locked) |-> !data_vld);

    p_start_inside_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (data_vld && frame_valid));
endmodule

// File: tb/test_fsync_top.sv
module test_fsync_top;
    localparam logic [31:0] SW = 32'hB4E2_7D19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_vld = 1'b0;
    logic [15:0] frame_len = 16'd64;
    logic [31:0] sync_word = SW;
    logic [31:0] sync_mask = '0;
    logic [3:0]  err_thr = 4'd2;
    logic [3:0]  ctl_thr = 4'd0;
    logic [3:0]  lts_thr = 4'd0;
    logic [1:0]  slip_win = 2'd0;
    logic        data_out, data_vld, frame_start, frame_valid, locked;
    logic [1:0]  state_out;

    int          n_chk = 0;
    int          n_bad = 0;
    int          cycles = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] coll = '0;

    always #4 clk = ~clk;

    fsync_top i_fsync_top (
        .clk(clk), .rst_n(rst_n), .enable(enable), .bit_in(bit_in), .bit_vld(bit_vld),
        .frame_len(frame_len), .sync_word(sync_word), .sync_mask(sync_mask),
        .err_thr(err_thr), .ctl_thr(ctl_thr), .lts_thr(lts_thr), .slip_win(slip_win),
        .data_out(data_out), .data_vld(data_vld), .frame_start(frame_start),
        .frame_valid(frame_valid), .state_out(state_out), .locked(locked)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
            summary();
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        bit_in  = b;
        bit_vld = 1'b1;
        @(negedge clk);
        coll = {coll[30:0], data_out};
    endtask

    task automatic idle(input int n);
        bit_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pay(input int n);
        for (int k = 0; k < n; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send_bit(lfsr[0]);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int k = 31; k >= 0; k--) send_bit(w[k]);
    endtask

    task automatic send_sync(input logic [31:0] flip);
        send_word(SW ^ flip);
    endtask

    task automatic restart();
        enable = 1'b0;
        idle(1);
        enable = 1'b1;
    endtask

    task automatic t_reset();
        check("R10 reset state", state_out, 0);
        check("R10 reset locked", locked, 0);
        check("R10 reset data_vld", data_vld, 0);
        check("R10 reset frame_valid", frame_valid, 0);
    endtask

    task automatic t_bypass();
        enable = 1'b0;
        send_bit(1'b1);
        check("R1 bypass bit 1", data_out, 1);
        check("R1 bypass vld", data_vld, 1);
        send_bit(1'b0);
        check("R1 bypass bit 0", data_out, 0);
        check("R1 bypass no flags", {frame_start, frame_valid}, 0);
        idle(1);
        check("R1 bypass idle vld", data_vld, 0);
    endtask

    task automatic t_acquire();
        err_thr = 4'd2; ctl_thr = 4'd2; lts_thr = 4'd1; slip_win = 2'd0;
        enable = 1'b1;
        send_pay(20);
        check("R2 no hit in noise", state_out, 0);
        send_sync(32'hE000_0000);
        check("R2 three errors rejected", state_out, 0);
        send_pay(10);
        send_sync(32'h0);
        check("R2 search-hit to CHECK", state_out, 1);
        send_word(SW);
        check("R4 payload sync ignored", state_out, 1);
        check("R5 no data in CHECK", data_vld, 0);
        idle(3);
        check("R10 state holds without strobe", state_out, 1);
        send_sync(32'hC000_0000);
        check("R5 second sync still CHECK", state_out, 1);
        send_pay(32);
        send_sync(32'h0);
        check("R5 third sync gives LOCK", state_out, 2);
        check("R9 frame_start on lock", frame_start, 1);
        check("R9 first bit is sync MSB", data_out, int'(SW[31]));
        check("R10 locked", locked, 1);
        check("R9 frame_valid", frame_valid, 1);
        send_pay(31);
        check("R9 delayed sync bits", int'(coll[30:0]), int'(SW[30:0]));
        send_pay(1);
        send_sync(32'h0);
        check("R6 next frame start N=0", frame_start, 1);
    endtask

    task automatic t_checkfail();
        restart();
        ctl_thr = 4'd1;
        send_pay(8);
        send_sync(32'h0);
        check("R4 enter CHECK", state_out, 1);
        send_pay(32);
        send_sync(32'h0000_0007);
        check("R4 check-fail to SEARCH", state_out, 0);
        check("R5 no data after fail", data_vld, 0);
    endtask

    task automatic t_mask();
        restart();
        err_thr = 4'd0; ctl_thr = 4'd0; sync_mask = 32'h0000_00FF;
        send_pay(8);
        send_sync(32'h0000_00A5);
        check("R3 masked errors match", state_out, 2);
        check("R5 i=0 start on first sync", frame_start, 1);
        sync_mask = '0;
    endtask

    task automatic t_fly();
        err_thr = 4'd1; lts_thr = 4'd2;
        send_pay(32);
        send_sync(32'h0000_000F);
        check("R7 miss enters FLYWHEEL", state_out, 3);
        check("R9 no start on miss", frame_start, 0);
        check("R7 data continues", data_vld, 1);
        check("R7 frame_valid held", frame_valid, 1);
        send_pay(32);
        send_sync(32'h0);
        check("R8 fly-hit to LOCK", state_out, 2);
        check("R8 start on fly-hit", frame_start, 1);
        send_pay(32);
        send_sync(32'hF000_0000);
        check("R8 miss one", state_out, 3);
        send_pay(32);
        send_sync(32'hF000_0000);
        check("R8 run cleared, miss two flywheels", state_out, 3);
        send_pay(32);
        send_sync(32'hF000_0000);
        check("R7 third miss to SEARCH", state_out, 0);
        check("R7 locked drops", locked, 0);
        lts_thr = 4'd0;
        send_pay(5);
        send_sync(32'h0);
        check("R5 relock i=0", state_out, 2);
        send_pay(32);
        send_sync(32'hF000_0000);
        check("R7 j=0 miss to SEARCH", state_out, 0);
        send_pay(3);
        send_sync(32'h0);
        enable = 1'b0;
        send_bit(1'b1);
        check("R1 disable clears state", state_out, 0);
        check("R1 disable flags", {frame_start, frame_valid}, 0);
        check("R1 disable copies bit", data_out, 1);
    endtask

    task automatic t_slip();
        restart();
        err_thr = 4'd0; ctl_thr = 4'd0; lts_thr = 4'd1; slip_win = 2'd1;
        send_pay(6);
        send_sync(32'h0);
        check("R6 lock", state_out, 2);
        send_pay(33);
        send_sync(32'h0);
        check("R6 late slip accepted", frame_start, 1);
        check("R6 late slip state", state_out, 2);
        send_pay(32);
        send_sync(32'h0);
        check("R6 realigned after late", frame_start, 1);
        send_pay(31);
        send_sync(32'h0);
        check("R6 early slip accepted", frame_start, 1);
        send_pay(32);
        send_sync(32'h0);
        check("R6 realigned after early", frame_start, 1);
        send_pay(34);
        send_sync(32'h0);
        check("R6 slip beyond window misses", state_out, 3);
        check("R6 no start beyond window", frame_start, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_acquire();
        t_checkfail();
        t_mask();
        t_fly();
        t_slip();
        idle(2);
        summary();
        $finish;
    end
endmodule